// File: doc/BRIEF.md
# Single-Level Trap Entry Unit

This block carries out the entry sequence of a trap for a processor that has register windows and a single global trap-enable flag. When the pipeline presents a trap request with an 8-bit trap type, together with the current program counter and next program counter, the unit checks the enable flag. If traps are enabled it clears the flag, rotates the current window pointer down by one (wrapping modulo the window count, with no invalid-window test), moves the supervisor bit into the previous-supervisor bit and sets supervisor. It then stores the trap type into the vector field of the trap base register, writes the saved program counters into two local registers of the new window, and redirects fetch to the vector address.

The register file is reached through one write port, so the two saves take two consecutive cycles; the fetch redirect and, for external-interrupt traps, an acknowledge to the interrupt controller happen in the second. A trap that arrives while traps are disabled stops the unit for good: it enters an error halt, or, when the shutdown option is built in and the trap type is the designated software trap, it raises a shutdown request instead. The processor's own status writes (enable, supervisor bits, window pointer, trap base) reach the unit through a load port.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the flags read trap-enable 1, supervisor 1, previous-supervisor 0, window pointer 0 and trap base register 0; busy, register write, redirect, acknowledge, error halt and shutdown are all 0.
- R2: A trap request sampled while idle with trap-enable 1 is accepted; from the next cycle trap-enable reads 0 and the window pointer reads the old value minus one modulo the window count (0 becomes window count minus one), with no invalid-window check.
- R3: On acceptance the previous-supervisor bit takes the old supervisor bit and the supervisor bit becomes 1.
- R4: On acceptance the trap base register keeps bits 31:12, takes the trap type in bits 11:4 and holds 0 in bits 3:0.
- R5: In the first cycle after acceptance the unit writes the sampled program counter to register index 17 (local register 1) of the new window.
- R6: In the second cycle after acceptance it writes the sampled next program counter to register index 18 (local register 2) of the new window, and asserts the fetch redirect with target equal to the new trap base register and next target equal to that value plus 4.
- R7: The interrupt acknowledge is a one-cycle pulse in the redirect cycle, given exactly when trap type bits 7:4 equal 1 (types 0x10 to 0x1F), and it carries the trap type.
- R8: Busy is 1 for the two cycles after acceptance; trap requests and loads presented in those cycles have no effect.
- R9: A trap request sampled while idle with trap-enable 0 sets the error halt, except that with the shutdown option enabled and trap type 0x80 it sets the shutdown request instead; each stays set until reset and the two are never set together.
- R10: Once halted, neither trap requests nor loads change any flag, the window pointer or the trap base register, and no register write, redirect or acknowledge is produced.
- R11: A load sampled while idle without a trap request writes trap-enable, supervisor, previous-supervisor, window pointer and trap base bits 31:12 from the next cycle; a trap request in the same cycle takes priority and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap request from the pipeline |
| trap_tt | input | 8 | Trap type of the request |
| trap_pc | input | 32 | Program counter at the trap |
| trap_npc | input | 32 | Next program counter at the trap |
| ld_en | input | 1 | Load the status fields below |
| ld_et | input | 1 | Trap-enable value to load |
| ld_s | input | 1 | Supervisor value to load |
| ld_ps | input | 1 | Previous-supervisor value to load |
| ld_cwp | input | 3 | Window pointer value to load |
| ld_tbase | input | 20 | Trap base bits 31:12 to load |
| busy | output | 1 | Entry sequence in progress |
| rf_we | output | 1 | Register file write enable |
| rf_win | output | 3 | Window of the write |
| rf_idx | output | 5 | Register index within the window |
| rf_wdata | output | 32 | Write data |
| fetch_redir | output | 1 | Fetch redirect strobe |
| fetch_pc | output | 32 | New program counter |
| fetch_npc | output | 32 | New next program counter |
| irq_ack | output | 1 | Interrupt acknowledge pulse |
| irq_ack_tt | output | 8 | Trap type carried by the acknowledge |
| st_et | output | 1 | Current trap-enable flag |
| st_s | output | 1 | Current supervisor flag |
| st_ps | output | 1 | Current previous-supervisor flag |
| st_cwp | output | 3 | Current window pointer |
| st_tbr | output | 32 | Current trap base register |
| halt_err | output | 1 | Sticky error halt |
| halt_shut | output | 1 | Sticky shutdown request |

## Verification
All flags, the window pointer and the trap base register are visible on the status outputs, so a wrong update from an acceptance or a load shows on those ports one cycle after the sampling edge. A sequencer that skips or repeats a phase shows within two cycles as a missing or extra register write, a redirect in the wrong cycle, or busy held the wrong length. A wrong window decrement is seen twice, on the window pointer and on the window of both saves, and a wrong interrupt decode shows as an acknowledge present or absent in the redirect cycle. A halt that is not sticky shows at the next trap request as state that moves when it should not.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   typedef enum logic [2:0] {
      PH_IDLE     = 3'd0,
      PH_SAVE_PC  = 3'd1,
      PH_SAVE_NPC = 3'd2,
      PH_ERROR    = 3'd3,
      PH_SHUTDOWN = 3'd4
   } phase_e;

   function automatic logic phase_halted(phase_e ph);
      return (ph == PH_ERROR) || (ph == PH_SHUTDOWN);
   endfunction

endpackage

// File: rtl/trap_wptr.sv
module trap_wptr #(
   parameter int NWIN    = 8,
   parameter int CWP_W   = 3,
   parameter int RST_CWP = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [CWP_W-1:0] ld_cwp,
   input  logic             rot_en,
   output logic [CWP_W-1:0] cwp
);
   localparam bit POW2 = (NWIN == (1 << CWP_W));
   localparam logic [CWP_W-1:0] TOP_WIN = CWP_W'(NWIN - 1);

   logic [CWP_W-1:0] cwp_q;
   logic [CWP_W-1:0] cwp_dec;

   generate
      if (NWIN < 2) begin : g_bad_nwin
         $error("trap_wptr: NWIN must be at least 2");
      end
      if (RST_CWP >= NWIN) begin : g_bad_rst
         $error("trap_wptr: RST_CWP out of range");
      end
      if (POW2) begin : g_wrap_free
         assign cwp_dec = cwp_q - 1'b1;
      end else begin : g_wrap_cmp
         assign cwp_dec = (cwp_q == '0) ? TOP_WIN : cwp_q - 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cwp_q <= CWP_W'(RST_CWP);
      else if (rot_en) cwp_q <= cwp_dec;
      else if (ld_en)  cwp_q <= ld_cwp;
   end

   assign cwp = cwp_q;

   assert_cwp_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(cwp_q) < NWIN));

   assert_cwp_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rot_en |=> ((($past(cwp_q) == '0) && (cwp_q == TOP_WIN)) ||
                  (($past(cwp_q) != '0) && (32'(cwp_q) + 1 == 32'($past(cwp_q))))));

endmodule

// File: rtl/trap_status_flags.sv
module trap_status_flags #(
   parameter bit RST_ET = 1'b1,
   parameter bit RST_S  = 1'b1,
   parameter bit RST_PS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enter,
   input  logic ld_en,
   input  logic ld_et,
   input  logic ld_s,
   input  logic ld_ps,
   output logic et,
   output logic s,
   output logic ps
);
   logic et_q, s_q, ps_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         et_q <= RST_ET;
         s_q  <= RST_S;
         ps_q <= RST_PS;
      end else if (enter) begin
         et_q <= 1'b0;
         ps_q <= s_q;
         s_q  <= 1'b1;
      end else if (ld_en) begin
         et_q <= ld_et;
         s_q  <= ld_s;
         ps_q <= ld_ps;
      end
   end

   assign et = et_q;
   assign s  = s_q;
   assign ps = ps_q;

   assert_enter_needs_et_R2: assert property (@(posedge clk) disable iff (!rst_n)
      enter |-> et_q);

   assert_enter_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> (s_q && !et_q && (ps_q == $past(s_q))));

endmodule

// File: rtl/trap_vector_base.sv
module trap_vector_base #(
   parameter int XLEN     = 32,
   parameter int TT_W     = 8,
   parameter int TT_SHIFT = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             enter,
   input  logic [TT_W-1:0]                  enter_tt,
   input  logic                             ld_en,
   input  logic [XLEN-TT_W-TT_SHIFT-1:0]    ld_base,
   output logic [XLEN-1:0]                  tbr,
   output logic [XLEN-1:0]                  vec_npc
);
   localparam int BASE_LSB = TT_W + TT_SHIFT;
   localparam int BASE_W   = XLEN - BASE_LSB;
   localparam int STEP     = 4;

   generate
      if (TT_SHIFT < 1) begin : g_bad_shift
         $error("trap_vector_base: TT_SHIFT must be at least 1");
      end
      if (BASE_W < 1) begin : g_bad_xlen
         $error("trap_vector_base: XLEN too small for the type field");
      end
   endgenerate

   logic [BASE_W-1:0] base_q;
   logic [TT_W-1:0]   tt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         tt_q   <= '0;
      end else if (enter) begin
         tt_q   <= enter_tt;
      end else if (ld_en) begin
         base_q <= ld_base;
      end
   end

   assign tbr     = {base_q, tt_q, {TT_SHIFT{1'b0}}};
   assign vec_npc = tbr + XLEN'(STEP);

   assert_base_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> $stable(tbr[XLEN-1:BASE_LSB]));

   assert_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tbr[TT_SHIFT-1:0] == '0));

endmodule

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
   import trap_entry_pkg::*;
#(
   parameter int          TT_W    = 8,
   parameter bit          SHUT_EN = 1'b1,
   parameter int          SHUT_TT = 8'h80
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trap_req,
   input  logic [TT_W-1:0] trap_tt,
   input  logic            et,
   input  logic            ld_req,
   output phase_e          phase,
   output logic            accept,
   output logic            ld_take
);
   phase_e ph_q, ph_d;
   logic   idle;
   logic   fault;
   logic   shut_hit;

   generate
      if (SHUT_EN) begin : g_shut
         assign shut_hit = (trap_tt == TT_W'(SHUT_TT));
      end else begin : g_no_shut
         assign shut_hit = 1'b0;
      end
   endgenerate

   assign idle    = (ph_q == PH_IDLE);
   assign accept  = idle && trap_req && et;
   assign fault   = idle && trap_req && !et;
   assign ld_take = idle && ld_req && !trap_req;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE: begin
            if (accept)     ph_d = PH_SAVE_PC;
            else if (fault) ph_d = shut_hit ? PH_SHUTDOWN : PH_ERROR;
         end
         PH_SAVE_PC:  ph_d = PH_SAVE_NPC;
         PH_SAVE_NPC: ph_d = PH_IDLE;
         PH_ERROR:    ph_d = PH_ERROR;
         PH_SHUTDOWN: ph_d = PH_SHUTDOWN;
         default:     ph_d = PH_ERROR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign phase = ph_q;

   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      phase_halted(ph_q) |=> (ph_q == $past(ph_q)));

   assert_seq_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_SAVE_PC) |=> (ph_q == PH_SAVE_NPC));

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_entry_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int TT_W       = 8,
   parameter int TT_SHIFT   = 4,
   parameter int NWIN       = 8,
   parameter int CWP_W      = 3,
   parameter int IDX_W      = 5,
   parameter int LOCAL_BASE = 16,
   parameter int IRQ_GROUP  = 1,
   parameter bit SHUT_EN    = 1'b1,
   parameter int SHUT_TT    = 8'h80
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          trap_req,
   input  logic [TT_W-1:0]               trap_tt,
   input  logic [XLEN-1:0]               trap_pc,
   input  logic [XLEN-1:0]               trap_npc,
   input  logic                          ld_en,
   input  logic                          ld_et,
   input  logic                          ld_s,
   input  logic                          ld_ps,
   input  logic [CWP_W-1:0]              ld_cwp,
   input  logic [XLEN-TT_W-TT_SHIFT-1:0] ld_tbase,
   output logic                          busy,
   output logic                          rf_we,
   output logic [CWP_W-1:0]              rf_win,
   output logic [IDX_W-1:0]              rf_idx,
   output logic [XLEN-1:0]               rf_wdata,
   output logic                          fetch_redir,
   output logic [XLEN-1:0]               fetch_pc,
   output logic [XLEN-1:0]               fetch_npc,
   output logic                          irq_ack,
   output logic [TT_W-1:0]               irq_ack_tt,
   output logic                          st_et,
   output logic                          st_s,
   output logic                          st_ps,
   output logic [CWP_W-1:0]              st_cwp,
   output logic [XLEN-1:0]               st_tbr,
   output logic                          halt_err,
   output logic                          halt_shut
);
   localparam int GRP_W = TT_W - 4;
   localparam logic [IDX_W-1:0] IDX_SAVE_PC  = IDX_W'(LOCAL_BASE + 1);
   localparam logic [IDX_W-1:0] IDX_SAVE_NPC = IDX_W'(LOCAL_BASE + 2);

   generate
      if (CWP_W < $clog2(NWIN) || CWP_W < 1) begin : g_bad_cwp
         $error("trap_entry_unit: CWP_W too narrow for NWIN");
      end
      if (LOCAL_BASE + 2 >= (1 << IDX_W)) begin : g_bad_idx
         $error("trap_entry_unit: local registers exceed IDX_W");
      end
      if (TT_W < 5) begin : g_bad_tt
         $error("trap_entry_unit: TT_W must be at least 5");
      end
   endgenerate

   phase_e          phase;
   logic            accept;
   logic            ld_take;
   logic            flag_et;
   logic [XLEN-1:0] tbr;
   logic [XLEN-1:0] vec_npc;
   logic [XLEN-1:0] pc_q, npc_q;
   logic [TT_W-1:0] tt_q;
   logic            irq_class;

   trap_seq_ctrl #(
      .TT_W    (TT_W),
      .SHUT_EN (SHUT_EN),
      .SHUT_TT (SHUT_TT)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .trap_req (trap_req),
      .trap_tt  (trap_tt),
      .et       (flag_et),
      .ld_req   (ld_en),
      .phase    (phase),
      .accept   (accept),
      .ld_take  (ld_take)
   );

   trap_status_flags u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .enter (accept),
      .ld_en (ld_take),
      .ld_et (ld_et),
      .ld_s  (ld_s),
      .ld_ps (ld_ps),
      .et    (flag_et),
      .s     (st_s),
      .ps    (st_ps)
   );

   trap_wptr #(
      .NWIN  (NWIN),
      .CWP_W (CWP_W)
   ) u_wptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_en  (ld_take),
      .ld_cwp (ld_cwp),
      .rot_en (accept),
      .cwp    (st_cwp)
   );

   trap_vector_base #(
      .XLEN     (XLEN),
      .TT_W     (TT_W),
      .TT_SHIFT (TT_SHIFT)
   ) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .enter    (accept),
      .enter_tt (trap_tt),
      .ld_en    (ld_take),
      .ld_base  (ld_tbase),
      .tbr      (tbr),
      .vec_npc  (vec_npc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         npc_q <= '0;
         tt_q  <= '0;
      end else if (accept) begin
         pc_q  <= trap_pc;
         npc_q <= trap_npc;
         tt_q  <= trap_tt;
      end
   end

   assign irq_class = (tt_q[TT_W-1:4] == GRP_W'(IRQ_GROUP));

   always_comb begin
      rf_we       = 1'b0;
      rf_idx      = IDX_SAVE_PC;
      rf_wdata    = pc_q;
      fetch_redir = 1'b0;
      irq_ack     = 1'b0;
      unique case (phase)
         PH_SAVE_PC: begin
            rf_we = 1'b1;
         end
         PH_SAVE_NPC: begin
            rf_we       = 1'b1;
            rf_idx      = IDX_SAVE_NPC;
            rf_wdata    = npc_q;
            fetch_redir = 1'b1;
            irq_ack     = irq_class;
         end
         default: ;
      endcase
   end

   assign busy       = (phase == PH_SAVE_PC) || (phase == PH_SAVE_NPC);
   assign rf_win     = st_cwp;
   assign fetch_pc   = tbr;
   assign fetch_npc  = vec_npc;
   assign irq_ack_tt = tt_q;
   assign st_et      = flag_et;
   assign st_tbr     = tbr;
   assign halt_err   = (phase == PH_ERROR);
   assign halt_shut  = (phase == PH_SHUTDOWN);

   assert_ack_with_redir_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> fetch_redir);

   assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack);

   assert_redir_after_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && rf_idx == IDX_SAVE_PC) |=> (fetch_redir && rf_idx == IDX_SAVE_NPC));

   assert_redir_et_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_redir |-> (!st_et && st_s));

   assert_halt_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(halt_err && halt_shut));

   assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_err || halt_shut) |=> ($stable(st_tbr) && $stable(st_cwp) && !rf_we));

   assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(st_tbr));

endmodule

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
   localparam int NWIN = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_req = 1'b0;
   logic [7:0]  trap_tt = '0;
   logic [31:0] trap_pc = '0, trap_npc = '0;
   logic        ld_en = 1'b0, ld_et = 1'b0, ld_s = 1'b0, ld_ps = 1'b0;
   logic [2:0]  ld_cwp = '0;
   logic [19:0] ld_tbase = '0;
   logic        busy, rf_we, fetch_redir, irq_ack, st_et, st_s, st_ps, halt_err, halt_shut;
   logic [2:0]  rf_win, st_cwp;
   logic [4:0]  rf_idx;
   logic [31:0] rf_wdata, fetch_pc, fetch_npc, st_tbr;
   logic [7:0]  irq_ack_tt;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 0;

   always #5 clk = ~clk;

   trap_entry_unit dut (.*);

   // reference model state
   int         m_ph;   // 0 idle, 1 save pc, 2 save npc, 3 error, 4 shutdown
   bit         m_et, m_s, m_ps;
   int         m_cwp;
   bit [19:0]  m_base;
   bit [7:0]   m_tf;
   bit [31:0]  m_pc, m_npc;
   bit [7:0]   m_tt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_et = 1; m_s = 1; m_ps = 0; m_cwp = 0;
         m_base = '0; m_tf = '0; m_pc = '0; m_npc = '0; m_tt = '0;
      end else begin
         case (m_ph)
            0: begin
               if (trap_req) begin
                  if (!m_et) m_ph = (trap_tt == 8'h80) ? 4 : 3;
                  else begin
                     m_et = 0; m_ps = m_s; m_s = 1;
                     m_cwp = (m_cwp + NWIN - 1) % NWIN;
                     m_tf = trap_tt; m_tt = trap_tt;
                     m_pc = trap_pc; m_npc = trap_npc;
                     m_ph = 1;
                  end
               end else if (ld_en) begin
                  m_et = ld_et; m_s = ld_s; m_ps = ld_ps;
                  m_cwp = int'(ld_cwp); m_base = ld_tbase;
               end
            end
            1: m_ph = 2;
            2: m_ph = 0;
            default: ;
         endcase
      end
   end

   task automatic chk(input string rq, input string nm, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h at cycle %0d", rq, nm, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit [31:0] e_tbr;
         bit halted;
         halted = (m_ph >= 3);
         e_tbr = {m_base, m_tf, 4'b0};
         chk(halted ? "R10" : "R2", "st_et", 32'(st_et), 32'(m_et));
         chk(halted ? "R10" : "R2", "st_cwp", 32'(st_cwp), 32'(m_cwp));
         chk(halted ? "R10" : "R3", "st_s", 32'(st_s), 32'(m_s));
         chk(halted ? "R10" : "R3", "st_ps", 32'(st_ps), 32'(m_ps));
         chk(halted ? "R10" : "R4", "st_tbr", st_tbr, e_tbr);
         chk("R8", "busy", 32'(busy), 32'(m_ph == 1 || m_ph == 2));
         chk("R5", "rf_we", 32'(rf_we), 32'(m_ph == 1 || m_ph == 2));
         if (m_ph == 1) begin
            chk("R5", "rf_win", 32'(rf_win), 32'(m_cwp));
            chk("R5", "rf_idx", 32'(rf_idx), 32'd17);
            chk("R5", "rf_wdata", rf_wdata, m_pc);
         end
         if (m_ph == 2) begin
            chk("R6", "rf_win", 32'(rf_win), 32'(m_cwp));
            chk("R6", "rf_idx", 32'(rf_idx), 32'd18);
            chk("R6", "rf_wdata", rf_wdata, m_npc);
            chk("R6", "fetch_pc", fetch_pc, e_tbr);
            chk("R6", "fetch_npc", fetch_npc, e_tbr + 32'd4);
            if (m_tt[7:4] == 4'h1) chk("R7", "irq_ack_tt", 32'(irq_ack_tt), 32'(m_tt));
         end
         chk("R6", "fetch_redir", 32'(fetch_redir), 32'(m_ph == 2));
         chk("R7", "irq_ack", 32'(irq_ack), 32'(m_ph == 2 && m_tt[7:4] == 4'h1));
         chk("R9", "halt_err", 32'(halt_err), 32'(m_ph == 3));
         chk("R9", "halt_shut", 32'(halt_shut), 32'(m_ph == 4));
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic trap(input logic [7:0] tt, input logic [31:0] pc, input logic [31:0] npc);
      @(negedge clk);
      trap_req = 1; trap_tt = tt; trap_pc = pc; trap_npc = npc;
      @(negedge clk);
      trap_req = 0;
   endtask

   task automatic load(input bit et, input bit s, input bit ps, input logic [2:0] cwp, input logic [19:0] base);
      @(negedge clk);
      ld_en = 1; ld_et = et; ld_s = s; ld_ps = ps; ld_cwp = cwp; ld_tbase = base;
      @(negedge clk);
      ld_en = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      idle(2);
      rst_n = 1;
   endtask

   initial begin
      idle(3);
      rst_n = 1;
      @(negedge clk);
      // R1 explicit reset values
      chk("R1", "reset st_et", 32'(st_et), 32'd1);
      chk("R1", "reset st_s", 32'(st_s), 32'd1);
      chk("R1", "reset st_ps", 32'(st_ps), 32'd0);
      chk("R1", "reset st_cwp", 32'(st_cwp), 32'd0);
      chk("R1", "reset st_tbr", st_tbr, 32'd0);
      chk("R1", "reset busy", 32'(busy), 32'd0);
      // first trap from window 0 wraps to 7 (R2), plain type no ack
      trap(8'h05, 32'h0000_1000, 32'h0000_1004);
      chk("R2", "cwp wrap", 32'(st_cwp), 32'd7);
      idle(3);
      // load new base and flags (R11), supervisor 0
      load(1, 0, 1, 3'd3, 20'hABCDE);
      @(negedge clk);
      chk("R11", "loaded tbr base", st_tbr, 32'hABCD_E050);
      // interrupt trap with load in same cycle -> load dropped (R11), ack (R7)
      @(negedge clk);
      trap_req = 1; trap_tt = 8'h1A; trap_pc = 32'h2000; trap_npc = 32'h2004;
      ld_en = 1; ld_et = 1; ld_s = 1; ld_ps = 0; ld_cwp = 3'd6; ld_tbase = 20'h11111;
      @(negedge clk);
      trap_req = 0; ld_en = 0;
      chk("R11", "load dropped cwp", 32'(st_cwp), 32'd2);
      // trap and load while busy are ignored (R8)
      trap_req = 1; trap_tt = 8'h33; ld_en = 1;
      @(negedge clk);
      trap_req = 0; ld_en = 0;
      idle(3);
      // non-interrupt group 0x20 (R7: no ack)
      load(1, 1, 0, 3'd5, 20'h00400);
      trap(8'h20, 32'h3000, 32'h3004);
      idle(1);
      // group 0x1F edge
      load(1, 0, 0, 3'd1, 20'h00400);
      trap(8'h1F, 32'hFFFF_FFF0, 32'hFFFF_FFF4);
      idle(3);
      // disabled trap, type 0x80 -> shutdown (R9), then stays (R10)
      load(0, 1, 1, 3'd4, 20'h00002);
      trap(8'h80, 32'h4000, 32'h4004);
      trap(8'h05, 32'h5000, 32'h5004);
      load(1, 0, 0, 3'd0, 20'h00009);
      idle(2);
      chk("R10", "shut sticky", 32'(halt_shut), 32'd1);
      // reset, then error halt on other type
      do_reset();
      load(0, 1, 0, 3'd2, 20'h00001);
      trap(8'h33, 32'h6000, 32'h6004);
      chk("R9", "error halt", 32'(halt_err), 32'd1);
      trap(8'h80, 32'h7000, 32'h7004);
      load(1, 1, 1, 3'd7, 20'hFFFFF);
      idle(2);
      chk("R10", "error sticky cwp", 32'(st_cwp), 32'd2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule